// File: doc/BRIEF.md
# Iterative Single-Precision Square Root

This unit takes one IEEE 754 binary32 operand and returns its square root, a multi-cycle operation started by a one-cycle `start` strobe. It sorts the operand by class first. Zeros, infinities, NaNs and negative values are answered straight away. A positive normal or subnormal operand is normalized and its exponent is halved. The root significand is then built one bit per clock by a restoring shift-subtract recurrence. That recurrence yields one more bit than the result keeps, so the final remainder and the extra bit together settle the rounding.

The unit raises `busy` while a root is being formed. It pulses `done` for one cycle when the answer is ready. The result word and its two exception flags stay put after that until the next accepted `start`. The rounding mode is sampled together with the operand.

Top module: `fsqrt_iter`

## Requirements
- R1: A signaling NaN operand (exponent all ones, fraction nonzero, fraction bit 22 clear) gives the default NaN 0x7FC00000 with `invalid` set and `inexact` clear.
- R2: A quiet NaN operand (exponent all ones, fraction bit 22 set) is returned bit for bit, with both flags clear.
- R3: +0, -0 and +infinity are returned bit for bit with both flags clear, so the root of -0 is -0.
- R4: -infinity, and any negative operand that is nonzero and finite, gives 0x7FC00000 with `invalid` set and `inexact` clear.
- R5: For every operand covered by R1 to R4, `done` rises in the cycle after the edge that accepts `start`, and `busy` stays low.
- R6: For a positive normal or subnormal operand, `busy` is high for the 26 cycles that follow the accepting edge. `done` then pulses once while `busy` is low. `busy` and `done` are never high together.
- R7: For a positive finite operand, the 25-bit root q is floor(sqrt(M * 2^25)). Here M is the significand with its leading one at bit 23, doubled when the unbiased exponent is odd. When the root is inexact, rounding mode 2'b00 (nearest) adds q[0] to q and mode 2'b10 (toward +infinity) adds 2. Modes 2'b01 (toward zero) and 2'b11 (toward -infinity) leave q unchanged. The result is (q >> 1) + 0x3F000000 + (floor(e/2) << 23), where e is the unbiased exponent.
- R8: `inexact` is set exactly when q*q differs from M * 2^25 on the recurrence path. `inexact` is never set together with `invalid` or with a negative result.
- R9: A subnormal operand is shifted left until bit 23 holds a one. Its unbiased exponent is 1 - shift - 127, and it then follows R7.
- R10: A `start` while `busy` is high is ignored: the running operation keeps its timing and its result.
- R11: `done` lasts one cycle. `result`, `invalid` and `inexact` hold their values from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only while not busy |
| operand | input | 32 | Binary32 operand, sampled with start |
| rnd_mode | input | 2 | Rounding mode, sampled with start (00 nearest, 01 toward zero, 10 up, 11 down) |
| busy | output | 1 | Recurrence in progress |
| done | output | 1 | One-cycle strobe: result and flags are valid |
| result | output | 32 | Binary32 square root |
| invalid | output | 1 | Invalid-operation flag for the last operation |
| inexact | output | 1 | Inexact flag for the last operation |

## Verification
The bench builds the unit with its default widths, 8 exponent bits and 23 fraction bits, which is the true binary32 format. That setting puts every corner of R7 and R9 within reach: the smallest subnormal with its 23-place shift, the largest finite value, odd and even exponents on both sides of the bias, and perfect squares beside non-squares in all four rounding modes. A behavioural model based on an integer square root predicts the result word, both flags and the exact cycle of `busy` and `done` for every operation. The bench compares that prediction with the outputs on every clock.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } fclass_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_TOZERO  = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_FIN
    } phase_e;

endpackage

// File: rtl/fsqrt_classify.sv
module fsqrt_classify
    import fsqrt_pkg::*;
#(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int WIDTH  = 1 + EXP_W + FRAC_W
) (
    input  logic [WIDTH-1:0] op,
    output fclass_e          cls,
    output logic             neg
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    assign ex  = op[WIDTH-2:FRAC_W];
    assign fr  = op[FRAC_W-1:0];
    assign neg = op[WIDTH-1];

    always_comb begin
        if (&ex) begin
            if (fr == '0)            cls = CLS_INF;
            else if (fr[FRAC_W-1])   cls = CLS_QNAN;
            else                     cls = CLS_SNAN;
        end else if (ex == '0) begin
            cls = (fr == '0) ? CLS_ZERO : CLS_SUB;
        end else begin
            cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fsqrt_prenorm.sv
module fsqrt_prenorm #(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int WIDTH  = 1 + EXP_W + FRAC_W,
    localparam int RAD_W  = FRAC_W + 6,
    localparam int SEXP_W = EXP_W + 2,
    localparam int CNT_W  = $clog2(FRAC_W + 1)
) (
    input  logic [WIDTH-1:0]         op,
    output logic [RAD_W-1:0]         radicand,
    output logic signed [SEXP_W-1:0] half_exp
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [SEXP_W-1:0] BIAS_S = SEXP_W'(BIAS);
    localparam logic signed [SEXP_W-1:0] ONE_S  = SEXP_W'(1);

    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    assign ex = op[WIDTH-2:FRAC_W];
    assign fr = op[FRAC_W-1:0];

    always_comb begin
        logic [CNT_W-1:0]         lead;
        logic [CNT_W-1:0]         shamt;
        logic [FRAC_W:0]          sig;
        logic signed [SEXP_W-1:0] uexp;
        logic [RAD_W-1:0]         rad;

        // highest set fraction bit, for subnormal normalization
        lead = '0;
        for (int k = 0; k < FRAC_W; k++) begin
            if (fr[k]) lead = CNT_W'(k);
        end
        shamt = CNT_W'(FRAC_W) - lead;

        if (ex == '0) begin
            sig  = {1'b0, fr} << shamt;
            uexp = ONE_S - $signed({{(SEXP_W-CNT_W){1'b0}}, shamt});
        end else begin
            sig  = {1'b1, fr};
            uexp = $signed({2'b00, ex});
        end
        uexp = uexp - BIAS_S;

        rad = {{(RAD_W-FRAC_W-1){1'b0}}, sig};
        if (uexp[0]) rad = rad << 1;
        radicand = rad << 1;
        half_exp = uexp >>> 1;
    end
endmodule

// File: rtl/fsqrt_step.sv
module fsqrt_step #(
    parameter int W = 29
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] q_i,
    input  logic [W-1:0] r_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] s_o,
    output logic [W-1:0] q_o,
    output logic [W-1:0] r_o
);
    always_comb begin
        logic [W-1:0] trial;
        logic [W-1:0] rem_n;
        trial = s_i + r_i;
        if (trial <= rem_i) begin
            s_o   = trial + r_i;
            rem_n = rem_i - trial;
            q_o   = q_i + r_i;
        end else begin
            s_o   = s_i;
            rem_n = rem_i;
            q_o   = q_i;
        end
        rem_o = rem_n << 1;
        r_o   = r_i >> 1;
    end
endmodule

// File: rtl/fsqrt_pack.sv
module fsqrt_pack
    import fsqrt_pkg::*;
#(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int WIDTH  = 1 + EXP_W + FRAC_W,
    localparam int QW     = FRAC_W + 6,
    localparam int SEXP_W = EXP_W + 2
) (
    input  logic [QW-1:0]            q,
    input  logic                     rnd_up,
    input  rmode_e                   rm,
    input  logic signed [SEXP_W-1:0] half_exp,
    output logic [WIDTH-1:0]         word
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [WIDTH-1:0] BASE = WIDTH'(BIAS - 1) << FRAC_W;

    logic [WIDTH-1:0] exp_sext;
    assign exp_sext = {{(WIDTH-SEXP_W){half_exp[SEXP_W-1]}}, half_exp};

    always_comb begin
        logic [QW-1:0] qr;
        qr = q;
        if (rnd_up) begin
            case (rm)
                RM_UP:      qr = q + QW'(2);
                RM_NEAREST: qr = q + {{(QW-1){1'b0}}, q[0]};
                default:    qr = q;
            endcase
        end
        word = WIDTH'(qr >> 1) + BASE + (exp_sext << FRAC_W);
    end
endmodule

// File: rtl/fsqrt_iter.sv
module fsqrt_iter
    import fsqrt_pkg::*;
#(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int WIDTH  = 1 + EXP_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] operand,
    input  logic [1:0]       rnd_mode,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    localparam int W      = FRAC_W + 6;
    localparam int SEXP_W = EXP_W + 2;
    localparam logic [WIDTH-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0]     R_INIT  = W'(1) << (FRAC_W + 1);

    typedef struct packed {
        phase_e                   phase;
        logic [W-1:0]             rem;
        logic [W-1:0]             s;
        logic [W-1:0]             q;
        logic [W-1:0]             r;
        logic signed [SEXP_W-1:0] hexp;
        rmode_e                   rm;
        logic [WIDTH-1:0]         res;
        logic                     inv;
        logic                     inx;
        logic                     done;
    } state_t;

    state_t st_q, st_d;

    fclass_e                  cls;
    logic                     neg;
    logic [W-1:0]             rad;
    logic signed [SEXP_W-1:0] hexp;
    logic [W-1:0]             rem_n, s_n, q_n, r_n;
    logic [WIDTH-1:0]         packed_w;

    fsqrt_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .op (operand),
        .cls(cls),
        .neg(neg)
    );

    fsqrt_prenorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .op      (operand),
        .radicand(rad),
        .half_exp(hexp)
    );

    fsqrt_step #(.W(W)) u_step (
        .rem_i(st_q.rem), .s_i(st_q.s), .q_i(st_q.q), .r_i(st_q.r),
        .rem_o(rem_n),    .s_o(s_n),    .q_o(q_n),    .r_o(r_n)
    );

    fsqrt_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
        .q       (st_q.q),
        .rnd_up  (st_q.rem != '0),
        .rm      (st_q.rm),
        .half_exp(st_q.hexp),
        .word    (packed_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.inv = 1'b0;
                    st_d.inx = 1'b0;
                    st_d.rm  = rmode_e'(rnd_mode);
                    case (cls)
                        CLS_SNAN: begin
                            st_d.res  = DEF_NAN;
                            st_d.inv  = 1'b1;
                            st_d.done = 1'b1;
                        end
                        CLS_QNAN, CLS_ZERO: begin
                            st_d.res  = operand;
                            st_d.done = 1'b1;
                        end
                        CLS_INF: begin
                            st_d.res  = neg ? DEF_NAN : operand;
                            st_d.inv  = neg;
                            st_d.done = 1'b1;
                        end
                        default: begin
                            if (neg) begin
                                st_d.res  = DEF_NAN;
                                st_d.inv  = 1'b1;
                                st_d.done = 1'b1;
                            end else begin
                                st_d.phase = PH_RUN;
                                st_d.rem   = rad;
                                st_d.s     = '0;
                                st_d.q     = '0;
                                st_d.r     = R_INIT;
                                st_d.hexp  = hexp;
                            end
                        end
                    endcase
                end
            end
            PH_RUN: begin
                st_d.rem = rem_n;
                st_d.s   = s_n;
                st_d.q   = q_n;
                st_d.r   = r_n;
                if (r_n == '0) st_d.phase = PH_FIN;
            end
            PH_FIN: begin
                st_d.res   = packed_w;
                st_d.inx   = (st_q.rem != '0);
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = (st_q.phase != PH_IDLE);
    assign done    = st_q.done;
    assign result  = st_q.res;
    assign invalid = st_q.inv;
    assign inexact = st_q.inx;
endmodule

// File: rtl/fsqrt_iter_chk.sv
module fsqrt_iter_chk #(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int WIDTH  = 1 + EXP_W + FRAC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result,
    input logic             invalid,
    input logic             inexact
);
    localparam logic [WIDTH-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !busy) |=> ($stable(result) && $stable(invalid) && $stable(inexact)));

    // R4
    invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> (result == DEF_NAN));

    // R8
    inexact_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && inexact) |-> (!invalid && !result[WIDTH-1]));
endmodule

bind fsqrt_iter fsqrt_iter_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .invalid(invalid),
    .inexact(inexact)
);

// File: tb/fsqrt_iter_bench.sv
module fsqrt_iter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  rnd_mode = '0;
    logic        busy, done, invalid, inexact;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsqrt_iter u_fsqrt_iter (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .rnd_mode(rnd_mode), .busy(busy), .done(done), .result(result),
        .invalid(invalid), .inexact(inexact)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic longint isqrt(input longint n);
        longint lo = 0, hi = longint'(1) << 27;
        while (lo < hi) begin
            longint mid = (lo + hi + 1) >> 1;
            if (mid * mid <= n) lo = mid; else hi = mid - 1;
        end
        return lo;
    endfunction

    // behavioural expectation from the requirements
    task automatic model(input logic [31:0] op, input logic [1:0] rm,
                         output logic [31:0] r, output bit inv, output bit inx, output int lat);
        bit      sg = op[31];
        int      ex = int'(op[30:23]);
        longint  m  = longint'(op[22:0]);
        longint  n, q;
        int      h;
        inv = 0; inx = 0; lat = 0; r = op;
        if (ex == 255) begin
            if (m == 0 && sg)   begin r = 32'h7FC00000; inv = 1; end
            else if (m != 0 && !op[22]) begin r = 32'h7FC00000; inv = 1; end
        end else if (ex == 0 && m == 0) begin
            r = op;
        end else if (sg) begin
            r = 32'h7FC00000; inv = 1;
        end else begin
            lat = 26;
            if (ex == 0) begin
                ex = 1;
                while (m < (longint'(1) << 23)) begin m = m * 2; ex = ex - 1; end
            end else begin
                m = m + (longint'(1) << 23);
            end
            ex = ex - 127;
            if ((ex & 1) != 0) m = m * 2;
            h = ex >>> 1;
            n = m << 25;
            q = isqrt(n);
            inx = (q * q != n);
            if (inx) begin
                if (rm == 2'b10) q = q + 2;
                else if (rm == 2'b00) q = q + (q & 1);
            end
            r = 32'(int'(q >> 1) + 32'h3F000000 + (h << 23));
        end
    endtask

    task automatic run(input logic [31:0] op, input logic [1:0] rm, input string tag, input bit poke);
        logic [31:0] er;
        bit          einv, einx;
        int          lat;
        string       ttag;
        model(op, rm, er, einv, einx, lat);
        ttag = (lat == 0) ? "R5" : "R6";
        if (poke) ttag = "R10";
        start = 1'b1; operand = op; rnd_mode = rm;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= lat; j++) begin
            if (j > 0) @(negedge clk);
            check(busy == (j < lat), {ttag, " busy"}, 32'(busy), 32'(j < lat));
            check(done == (j == lat), {ttag, " done"}, 32'(done), 32'(j == lat));
            if (poke && j == 4) begin start = 1'b1; operand = 32'h40800000; rnd_mode = 2'b10; end
            else start = 1'b0;
        end
        check(result == er, {tag, " result"}, result, er);
        check(invalid == einv, {tag, " invalid"}, 32'(invalid), 32'(einv));
        check(inexact == einx, (lat != 0) ? "R8 inexact" : {tag, " inexact"}, 32'(inexact), 32'(einx));
        @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R11 done pulse", 32'(done), 32'h0);
        check(result == er, "R11 result held", result, er);
        check(invalid == einv && inexact == einx, "R11 flags held",
              {30'h0, invalid, inexact}, {30'h0, einv, einx});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed = 32'h1F3A_C9E5;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R11 reset state", {30'h0, busy, done}, 32'h0);
        check(result == 32'h0, "R11 reset result", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run(32'h7FA00000, 2'b00, "R1", 0);
        run(32'hFF800001, 2'b00, "R1", 0);
        run(32'h7FC12345, 2'b00, "R2", 0);
        run(32'hFFC00001, 2'b01, "R2", 0);
        run(32'h00000000, 2'b00, "R3", 0);
        run(32'h80000000, 2'b10, "R3", 0);
        run(32'h7F800000, 2'b00, "R3", 0);
        run(32'hFF800000, 2'b00, "R4", 0);
        run(32'hBF800000, 2'b00, "R4", 0);
        run(32'h80000001, 2'b00, "R4", 0);

        run(32'h3F800000, 2'b00, "R7", 0);
        run(32'h40800000, 2'b00, "R7", 0);
        run(32'h7F7FFFFF, 2'b10, "R7", 0);
        for (int m = 0; m < 4; m++) begin
            run(32'h40000000, 2'(m), "R7", 0);
            run(32'h40400000, 2'(m), "R7", 0);
            run(32'h3E800001, 2'(m), "R7", 0);
        end

        run(32'h00000001, 2'b00, "R9", 0);
        run(32'h00000001, 2'b10, "R9", 0);
        run(32'h007FFFFF, 2'b00, "R9", 0);
        run(32'h00400000, 2'b01, "R9", 0);
        run(32'h00000003, 2'b11, "R9", 0);

        run(32'h40000000, 2'b00, "R10", 1);

        for (int i = 0; i < 40; i++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            run(seed, seed[1:0], "R7", 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule